// File: doc/BRIEF.md
# Queued SPI master controller

This block is an SPI master that works through a short list of byte transfers on its own once software has started it. Each list entry holds a command word, a byte to send and a slot for the byte that comes back. Software fills the command and transmit lists through an address register and a data port that steps forward after every access. It then sets a start bit and later collects the received bytes the same way. A finished flag tells software when the last entry has completed.

Every transfer is an 8-bit frame, sent MSB first. The clock polarity, the clock phase and a clock divisor are taken from a mode register. The command word of each entry picks which of the chip-select outputs it drives. It also says whether chip select stays asserted into the next entry. The register bus is a plain strobe interface with a combinational read path. A read of the data port advances its index on the clock edge that ends the read cycle.

The queue sequencer has four named states:

- **IDLE** waits for a start request.
- **LOAD** applies the entry's chip select and launches the byte.
- **RUN** waits for the byte engine to finish.
- **STORE** writes the received byte back.

The transitions are:

- IDLE→LOAD on an accepted start.
- LOAD→RUN always.
- RUN→STORE when the byte engine reports done.
- STORE→LOAD when more entries remain.
- STORE→IDLE after the last entry.

The byte engine has two states: SH_IDLE (SCK parked at its idle level) and SH_RUN (counting half periods).

Top module: `qspi_queue_master`

## Requirements
- R1: One start runs the entries from index 0 up to the end pointer, which sits in bits [3:0] of the wrap register (offset 2). That is end pointer + 1 frames, and no more.
- R2: The address register (offset 4) selects a region in bits [5:4] and an index in bits [3:0]. The region codes are 0 for transmit, 1 for receive and 2 for command. Each read or write of the data port (offset 5) moves the index on by one, and index 15 wraps to 0 within the same region.
- R3: A command word uses these bits: [7] continue, [6] bits-enable and [3:0] a one-hot chip-select choice. With continue set, chip select stays asserted from one entry to the next. With continue clear, chip select is released between entries. Every frame is 8 bits.
- R4: Writing bit 15 of the delay register (offset 3'd1) starts the queue, but only when the master-enable bit 15 of the mode register is set. The start bit reads back 1 while the queue runs and clears itself at the end. At that point bit 0 of the status register (offset 3) is set.
- R5: Writing 1 to status bit 0 clears the finished flag. Writing 0 leaves it unchanged.
- R6: The mode register (offset 0) holds these fields: [15] master enable, [13:10] frame length (read-back only), [9] CPOL, [8] CPHA and [7:0] divisor. The SCK period is 4 × divisor clocks, and a divisor below 2 behaves as 2.
- R7: Wrap register bit 12 sets the chip-select polarity. When it is 1, chip selects idle high and assert low. When it is 0, they idle low and assert high.
- R8: MOSI sends each byte MSB first. MISO is sampled on the leading SCK edge when CPHA=0 and on the trailing edge when CPHA=1. The received byte is stored at the receive index equal to the entry index.
- R9: When the queue ends, all chip selects return to their inactive level and SCK returns to the CPOL level.
- R10: A data-port write made while the queue runs changes neither the RAMs nor the index.
- R11: After reset, all registers read 0, SCK is low and all chip selects are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the data port) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NCS | Chip-select outputs |

## Verification
The assertions check the following on every cycle:

- SCK sits at the CPOL level whenever the byte engine is idle.
- The finished flag rises only out of the STORE state.
- The start bit never drops without the finished flag.
- A data-port write during a run leaves the index untouched.
- Chip selects stay at their idle level in IDLE.

Only the bench scenarios can show the rest:

- The serial data and its sampling edge in all four clock modes.
- The SCK period for each divisor.
- The number of frames per start.
- Chip-select release between entries, which depends on the continue bit.
- Index wrap and the write-one-to-clear behaviour, which are visible only through register traffic.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    typedef enum logic [1:0] {Q_IDLE, Q_LOAD, Q_RUN, Q_STORE} q_state_t;
    typedef enum logic {SH_IDLE, SH_RUN} sh_state_t;

    localparam logic [1:0] RG_TX  = 2'd0;
    localparam logic [1:0] RG_RX  = 2'd1;
    localparam logic [1:0] RG_CMD = 2'd2;

    localparam logic [2:0] OFS_MODE = 3'd0;
    localparam logic [2:0] OFS_DLY  = 3'd1;
    localparam logic [2:0] OFS_WRAP = 3'd2;
    localparam logic [2:0] OFS_STAT = 3'd3;
    localparam logic [2:0] OFS_ADDR = 3'd4;
    localparam logic [2:0] OFS_DATA = 3'd5;
endpackage

// File: rtl/qspi_qram.sv
module qspi_qram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift
    import qspi_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 8,
    localparam int CW = BW + 1,
    localparam int EW = $clog2(2 * DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tx,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [BW-1:0] baud,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          fin,
    output logic [DW-1:0] rx
);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

    sh_state_t     st;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [EW-1:0] edge_n;
    logic [BW-1:0] beff;
    logic [CW-1:0] half_m1;

    assign beff    = (baud < BW'(2)) ? BW'(2) : baud;
    assign half_m1 = {beff, 1'b0} - CW'(1);
    assign mosi    = sh[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SH_IDLE; sck <= 1'b0; sh <= '0; rx <= '0;
            cnt <= '0; edge_n <= '0; fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            unique case (st)
                SH_IDLE: begin
                    sck <= cpol;
                    if (start) begin
                        sh <= tx; cnt <= half_m1; edge_n <= '0; st <= SH_RUN;
                    end
                end
                SH_RUN: begin
                    if (cnt == '0) begin
                        cnt <= half_m1;
                        sck <= ~sck;
                        if (edge_n[0] == cpha)
                            rx <= {rx[DW-2:0], miso};
                        else if (edge_n != '0 && edge_n != LAST_EDGE)
                            sh <= {sh[DW-2:0], 1'b0};
                        if (edge_n == LAST_EDGE) begin
                            st <= SH_IDLE; fin <= 1'b1;
                        end else begin
                            edge_n <= edge_n + EW'(1);
                        end
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SH_IDLE && $past(st) == SH_IDLE) |-> sck == $past(cpol));
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
    import qspi_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int NCS     = 4,
    parameter int DW      = 8,
    localparam int IW     = $clog2(ENTRIES),
    localparam int CMDW   = 2 + NCS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     reg_addr,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [15:0]    reg_wdata,
    output logic [15:0]    reg_rdata,
    output logic           sck_o,
    output logic           mosi_o,
    input  logic           miso_i,
    output logic [NCS-1:0] cs_o
);
    q_state_t state, nxt;
    logic men, cpol, cpha, spe, csiv, done_q;
    logic [3:0] flen;
    logic [7:0] baud;
    logic [IW-1:0] endqp, ptr, qidx;
    logic [1:0] region;

    logic go, clr_done, last, data_acc, tx_we, cmd_we, rx_we, sh_start, sh_fin, cs_act;
    logic [DW-1:0] sh_rx;
    logic [1:0][DW-1:0]   tx_rd;
    logic [1:0][CMDW-1:0] cmd_rd;
    logic [0:0][DW-1:0]   rx_rd;

    assign go       = reg_wr && reg_addr == OFS_DLY && reg_wdata[15] && men && state == Q_IDLE;
    assign clr_done = reg_wr && reg_addr == OFS_STAT && reg_wdata[0];
    assign last     = (qidx == endqp);
    assign data_acc = reg_addr == OFS_DATA && ((reg_wr && !spe) || reg_rd);
    assign tx_we    = reg_wr && !spe && reg_addr == OFS_DATA && region == RG_TX;
    assign cmd_we   = reg_wr && !spe && reg_addr == OFS_DATA && region == RG_CMD;

    qspi_qram #(.DEPTH(ENTRIES), .WIDTH(DW), .NRD(2)) i_txram (
        .clk(clk), .we(tx_we), .waddr(ptr), .wdata(reg_wdata[DW-1:0]),
        .raddr({qidx, ptr}), .rdata(tx_rd));
    qspi_qram #(.DEPTH(ENTRIES), .WIDTH(CMDW), .NRD(2)) i_cmdram (
        .clk(clk), .we(cmd_we), .waddr(ptr),
        .wdata({reg_wdata[7:6], reg_wdata[NCS-1:0]}),
        .raddr({qidx, ptr}), .rdata(cmd_rd));
    qspi_qram #(.DEPTH(ENTRIES), .WIDTH(DW), .NRD(1)) i_rxram (
        .clk(clk), .we(rx_we), .waddr(qidx), .wdata(sh_rx),
        .raddr(ptr), .rdata(rx_rd));

    qspi_shift #(.DW(DW), .BW(8)) i_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(tx_rd[1]),
        .cpol(cpol), .cpha(cpha), .baud(baud), .miso(miso_i),
        .sck(sck_o), .mosi(mosi_o), .fin(sh_fin), .rx(sh_rx));

    // register bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            men <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; flen <= '0; baud <= '0;
            csiv <= 1'b0; endqp <= '0; region <= '0; ptr <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_MODE) begin
                men <= reg_wdata[15]; flen <= reg_wdata[13:10];
                cpol <= reg_wdata[9]; cpha <= reg_wdata[8]; baud <= reg_wdata[7:0];
            end
            if (reg_wr && reg_addr == OFS_WRAP) begin
                csiv <= reg_wdata[12]; endqp <= reg_wdata[IW-1:0];
            end
            if (reg_wr && reg_addr == OFS_ADDR) begin
                region <= reg_wdata[5:4]; ptr <= reg_wdata[IW-1:0];
            end else if (data_acc) begin
                ptr <= ptr + IW'(1);
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            Q_IDLE:  if (go) nxt = Q_LOAD;
            Q_LOAD:  nxt = Q_RUN;
            Q_RUN:   if (sh_fin) nxt = Q_STORE;
            Q_STORE: nxt = last ? Q_IDLE : Q_LOAD;
        endcase
    end

    // state register and queue counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_IDLE; qidx <= '0; spe <= 1'b0; done_q <= 1'b0;
        end else begin
            state <= nxt;
            if (clr_done) done_q <= 1'b0;
            if (go) begin
                qidx <= '0; spe <= 1'b1;
            end
            if (state == Q_STORE) begin
                if (last) begin
                    spe <= 1'b0; done_q <= 1'b1;
                end else begin
                    qidx <= qidx + IW'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        sh_start = (state == Q_LOAD);
        rx_we    = (state == Q_STORE);
        cs_act   = (state == Q_LOAD) || (state == Q_RUN) ||
                   (state == Q_STORE && cmd_rd[1][CMDW-1] && !last);
        cs_o     = {NCS{csiv}} ^ (cs_act ? cmd_rd[1][NCS-1:0] : '0);
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_MODE: reg_rdata = {men, 1'b0, flen, cpol, cpha, baud};
            OFS_DLY:  reg_rdata = {spe, 15'b0};
            OFS_WRAP: reg_rdata = (16'(csiv) << 12) | 16'(endqp);
            OFS_STAT: reg_rdata = 16'(done_q);
            OFS_ADDR: reg_rdata = (16'(region) << 4) | 16'(ptr);
            OFS_DATA: begin
                if (region == RG_TX)       reg_rdata = 16'(tx_rd[0]);
                else if (region == RG_RX)  reg_rdata = 16'(rx_rd[0]);
                else if (region == RG_CMD) reg_rdata = {8'b0, cmd_rd[0][CMDW-1:CMDW-2], 6'(cmd_rd[0][NCS-1:0])};
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_done_from_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(state) == Q_STORE);
    assert_spe_end_sets_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spe) |-> done_q);
    assert_run_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == OFS_DATA && spe) |=> $stable(ptr));
    assert_cs_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_IDLE) |-> cs_o == {NCS{csiv}});
endmodule

// File: tb/test_qspi_queue_master.sv
`timescale 1ns/1ps
module test_qspi_queue_master;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic sck_o, mosi_o, miso_i;
    logic [3:0] cs_o;

    int tests = 0, fails = 0;
    logic cpol_cfg = 0, cpha_cfg = 0, csiv_cfg = 0, mon_on = 0;
    int ch_cfg = 0, nbits = 0, nbytes = 0, cs_errs = 0, cs_asserts = 0, nlead = 0;
    logic [7:0] cap_sh = '0;
    logic [7:0] cap [16];
    logic [7:0] txb [16];
    realtime tl [2];
    logic lead;

    always #2.5 clk = ~clk;
    assign miso_i = ~mosi_o;  // inverted loopback slave

    qspi_queue_master i_qspi_queue_master (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o), .mosi_o(mosi_o),
        .miso_i(miso_i), .cs_o(cs_o));

    function automatic logic [7:0] exp_rx(input logic [7:0] t); return ~t; endfunction
    function automatic realtime exp_period(input int b); return 20.0 * ((b < 2) ? 2 : b); endfunction
    function automatic int exp_asserts(input int n, input logic cont); return cont ? 1 : n; endfunction

    always @(sck_o) if (mon_on) begin
        lead = (sck_o != cpol_cfg);
        if (lead && nlead < 2) begin tl[nlead] = $realtime; nlead++; end
        if (lead ^ cpha_cfg) begin
            cap_sh = {cap_sh[6:0], mosi_o};
            nbits++;
            for (int k = 0; k < 4; k++)
                if ((k == ch_cfg) == (cs_o[k] == csiv_cfg)) cs_errs++;
            if (nbits % 8 == 0) begin
                if (nbytes < 16) cap[nbytes] = cap_sh;
                nbytes++;
            end
        end
    end

    always @(cs_o) if (mon_on && cs_o[ch_cfg] != csiv_cfg) cs_asserts++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic run_queue(input int n, input logic cp, input logic ph, input int baud,
                             input logic inv, input int ch, input logic cont, input logic wr_run);
        logic [15:0] v;
        int guard;
        mon_on = 0; cpol_cfg = cp; cpha_cfg = ph; csiv_cfg = inv; ch_cfg = ch;
        bw(3'd0, 16'h8000 | (16'(cp) << 9) | (16'(ph) << 8) | 16'(baud[7:0]));
        bw(3'd2, (16'(inv) << 12) | 16'(n - 1));
        bw(3'd4, 16'h0020);
        for (int i = 0; i < n; i++) bw(3'd5, (16'(cont) << 7) | 16'h0040 | (16'h1 << ch));
        bw(3'd4, 16'h0000);
        for (int i = 0; i < n; i++) begin txb[i] = 8'($urandom); bw(3'd5, 16'(txb[i])); end
        bw(3'd3, 16'h0001);
        nbits = 0; nbytes = 0; cs_errs = 0; cs_asserts = 0; nlead = 0; mon_on = 1;
        bw(3'd1, 16'h8000);
        if (wr_run) bw(3'd5, 16'(~txb[0]));
        guard = 0;
        do begin br(3'd3, v); guard++; end while (!v[0] && guard < 20000);
        mon_on = 0;
        check("R4 done flag", 32'(v[0]), 1);
        br(3'd1, v); check("R4 start bit self-clear", 32'(v[15]), 0);
        check("R1 frame count", nbytes, n);
        for (int i = 0; i < n && i < 16; i++) check("R8 mosi byte", 32'(cap[i]), 32'(txb[i]));
        bw(3'd4, 16'h0010);
        for (int i = 0; i < n; i++) begin br(3'd5, v); check("R8 rx entry", 32'(v), 32'(exp_rx(txb[i]))); end
        check("R7 cs level during frames", cs_errs, 0);
        check("R3 cs assertions per continue", cs_asserts, exp_asserts(n, cont));
        check("R9 sck idle", 32'(sck_o), 32'(cp));
        check("R9 cs idle", 32'(cs_o), 32'({4{inv}}));
        check("R6 sck period", ((tl[1] - tl[0]) == exp_period(baud)) ? 1 : 0, 1);
        if (wr_run) begin
            bw(3'd4, 16'h0000); br(3'd5, v);
            check("R10 write during run ignored", 32'(v), 32'(txb[0]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check("R11 sck reset", 32'(sck_o), 0);
        check("R11 cs reset", 32'(cs_o), 0);
        br(3'd0, v); check("R11 mode reset", 32'(v), 0);
        br(3'd1, v); check("R11 delay reset", 32'(v), 0);
        br(3'd3, v); check("R11 status reset", 32'(v), 0);
        // R2 index wrap in transmit region
        bw(3'd4, 16'h000F); bw(3'd5, 16'h0011); bw(3'd5, 16'h0022);
        bw(3'd4, 16'h000F); br(3'd5, v); check("R2 tx index 15", 32'(v), 32'h11);
        br(3'd4, v); check("R2 index wrapped", 32'(v), 0);
        br(3'd5, v); check("R2 tx index 0", 32'(v), 32'h22);
        // R4 start ignored with master enable clear
        bw(3'd0, 16'h0004); bw(3'd1, 16'h8000);
        br(3'd1, v); check("R4 no start without enable", 32'(v[15]), 0);
        // directed corners
        run_queue(16, 0, 0, 2, 1, 0, 1, 1);
        run_queue(3, 1, 1, 1, 0, 2, 0, 0);   // divisor below 2
        run_queue(1, 0, 1, 3, 1, 3, 0, 0);
        // R5 write-one-to-clear
        bw(3'd3, 16'h0000); br(3'd3, v); check("R5 write 0 keeps flag", 32'(v[0]), 1);
        bw(3'd3, 16'h0001); br(3'd3, v); check("R5 write 1 clears flag", 32'(v[0]), 0);
        // constrained random queues
        for (int r = 0; r < 6; r++)
            run_queue(1 + int'($urandom % 16), 1'($urandom), 1'($urandom), 2 + int'($urandom % 4),
                      1'($urandom), int'($urandom % 4), 1'($urandom), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule